// File: doc/BRIEF.md
# Four-Phase Charge Pump Sequencer

This block drives the switch network of a regulated dual-rail charge pump. The pump makes a positive and a negative supply from one input supply using two flying capacitors. Two comparator flags report whether each rail magnitude has sagged below its regulation level. While either flag is raised, the sequencer steps through four phase slots in a fixed order: negative-rail charge storage, negative-rail transfer, positive-rail charge storage, positive-rail transfer. It then repeats the order. When neither flag is raised at the close of the positive-transfer slot, it halts and leaves every switch open. This gives discontinuous regulation. Each phase slot lasts a fixed number of system clocks, which sets the pump oscillator rate from the system clock.

Only three switch configurations exist, so the switch control is a one-hot vector with one bit per configuration:

- Bit 0, the doubler configuration, serves both charge-storage phases.
- Bit 1 serves the negative transfer.
- Bit 2 serves the positive transfer.

The opening clocks of every slot hold all switches open, so no two configurations ever overlap. A shutdown input aborts the pump at once. A rails-valid flag reports that both comparators have shown the rails in regulation since the last shutdown.

All pins are plain control and status levels. There is no data stream, so no handshake applies.

Top module: `cp_phase_seq`

## Requirements
- R1: While reset is low, `sw_en` is 000, `running` is 0 and `rails_valid` is 0.
- R2: When the pump is idle and `shdn` is low, a raised `pos_low` or `neg_low` sets `running` in the next cycle. The pump always starts at the negative-rail charge-storage phase, so the first switch configuration driven is bit 0.
- R3: While running, each phase slot lasts SLOT_CLKS cycles. The configurations follow the order bit 0, bit 1, bit 0, bit 2, and then repeat.
- R4: In the first DEAD_CLKS cycles of every slot, `sw_en` is 000. At no time is more than one bit of `sw_en` set.
- R5: Whenever `running` is 0, `sw_en` is 000.
- R6: If both flags drop during a run, the pump finishes the current positive-transfer slot and stops in the cycle after that slot's last cycle. Demand that is removed partway through a cycle does not stop the pump before that point.
- R7: If demand is still present at the end of the positive-transfer slot, the next slot is negative-rail charge storage, with no idle cycle between them.
- R8: A high `shdn` forces `running` to 0, `sw_en` to 000 and `rails_valid` to 0 in the next cycle, whatever the flags are. No start happens while `shdn` is high.
- R9: `rails_valid` rises only in the cycle after both flags were seen low with `shdn` low. After it rises, it stays high while a rail dips, until shutdown or reset.
- R10: A change from one nonzero switch configuration to a different one always passes through at least one cycle in which all switches are open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn | input | 1 | Shutdown request, active high |
| pos_low | input | 1 | Positive rail magnitude below regulation level |
| neg_low | input | 1 | Negative rail magnitude below regulation level |
| sw_en | output | 3 | One-hot switch configuration: bit 0 doubler (both storage phases), bit 1 negative transfer, bit 2 positive transfer |
| running | output | 1 | Pump sequencing is active |
| rails_valid | output | 1 | Both rails have reported regulation since the last shutdown |

## Verification
The assertions assume that `shdn`, `pos_low` and `neg_low` are already synchronous to `clk` and settle well before each rising edge. They also assume that DEAD_CLKS is smaller than SLOT_CLKS, so every slot has an active part. The stimulus meets these assumptions: it changes the inputs only one nanosecond after a rising edge and builds the design with six-clock slots of which two are dead. Comparator behaviour is supplied as arbitrary flag levels, not modelled analog rails. This lets the bench remove demand partway through a slot and pulse it for a single cycle.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;

  // Phase slots in the order the pump steps through them
  typedef enum logic [1:0] {
    PH_NEG_STORE = 2'd0,
    PH_NEG_XFER  = 2'd1,
    PH_POS_STORE = 2'd2,
    PH_POS_XFER  = 2'd3
  } phase_e;

  // Switch configuration vector: one bit per distinct configuration
  localparam int SW_W      = 3;
  localparam int SW_DOUBLE = 0;  // both storage phases
  localparam int SW_NEG    = 1;  // negative transfer
  localparam int SW_POS    = 2;  // positive transfer

endpackage

// File: rtl/cp_slot_timer.sv
module cp_slot_timer #(
  parameter int SLOT_CLKS = 100,
  parameter int DEAD_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic slot_end,
  output logic dead
);
  localparam int CW = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [CW-1:0] LAST   = CW'(SLOT_CLKS - 1);
  localparam logic [CW-1:0] DEAD_N = CW'(DEAD_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign slot_end = run && (cnt == LAST);
  assign dead     = (cnt < DEAD_N);

  // R3: a slot boundary is only reached after the count has advanced through the slot
  a_r3_slot_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cnt != '0) |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/cp_phase_fsm.sv
module cp_phase_fsm
  import cp_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shdn,
  input  logic   demand,
  input  logic   slot_end,
  output logic   run,
  output phase_e phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      phase <= PH_NEG_STORE;
    end else if (shdn) begin
      run   <= 1'b0;
      phase <= PH_NEG_STORE;
    end else if (!run) begin
      run   <= demand;
      phase <= PH_NEG_STORE;
    end else if (slot_end) begin
      if (phase == PH_POS_XFER) begin
        run   <= demand;
        phase <= PH_NEG_STORE;
      end else begin
        phase <= phase_e'(phase + 2'd1);
      end
    end
  end

  // R8: shutdown stops the sequence on the next edge
  a_r8_shdn_stops: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> !run);

  // R2: an idle pump with demand and no shutdown starts at storage of the negative rail
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !shdn && demand) |=> (run && phase == PH_NEG_STORE));

  // R6: the pump leaves the running state only on shutdown or at the end of the positive transfer
  a_r6_stop_point: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(shdn) || ($past(phase) == PH_POS_XFER && $past(slot_end))));

  // R7: consecutive slots advance one phase, wrapping to the first
  a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(slot_end)) |-> (phase == phase_e'($past(phase) + 2'd1)));

endmodule

// File: rtl/cp_switch_decode.sv
module cp_switch_decode
  import cp_seq_pkg::*;
(
  input  logic            run,
  input  logic            dead,
  input  phase_e          phase,
  output logic [SW_W-1:0] sw
);

  always_comb begin
    sw = '0;
    if (run && !dead) begin
      unique case (phase)
        PH_NEG_STORE, PH_POS_STORE: sw[SW_DOUBLE] = 1'b1;
        PH_NEG_XFER:                sw[SW_NEG]    = 1'b1;
        PH_POS_XFER:                sw[SW_POS]    = 1'b1;
        default:                    sw            = '0;
      endcase
    end
  end

endmodule

// File: rtl/cp_rail_monitor.sv
module cp_rail_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn,
  input  logic pos_low,
  input  logic neg_low,
  output logic rails_ok
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rails_ok <= 1'b0;
    else if (shdn)                  rails_ok <= 1'b0;
    else if (!pos_low && !neg_low)  rails_ok <= 1'b1;
  end

  // R9: the flag rises only after both rails were seen in regulation
  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rails_ok) |-> $past(!pos_low && !neg_low && !shdn));

  // R8: shutdown clears the flag
  a_r8_valid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> !rails_ok);

endmodule

// File: rtl/cp_phase_seq.sv
module cp_phase_seq
  import cp_seq_pkg::*;
#(
  parameter int SLOT_CLKS = 100,
  parameter int DEAD_CLKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shdn,
  input  logic            pos_low,
  input  logic            neg_low,
  output logic [SW_W-1:0] sw_en,
  output logic            running,
  output logic            rails_valid
);

  logic   slot_end;
  logic   dead;
  logic   run;
  phase_e phase;

  cp_slot_timer #(
    .SLOT_CLKS (SLOT_CLKS),
    .DEAD_CLKS (DEAD_CLKS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .slot_end (slot_end),
    .dead     (dead)
  );

  cp_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn     (shdn),
    .demand   (pos_low | neg_low),
    .slot_end (slot_end),
    .run      (run),
    .phase    (phase)
  );

  cp_switch_decode u_dec (
    .run   (run),
    .dead  (dead),
    .phase (phase),
    .sw    (sw_en)
  );

  cp_rail_monitor u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn     (shdn),
    .pos_low  (pos_low),
    .neg_low  (neg_low),
    .rails_ok (rails_valid)
  );

  assign running = run;

  // R4: never more than one configuration closed
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en));

  // R5: an idle pump keeps every switch open
  a_r5_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (sw_en == '0));

  // R10: two different closed configurations are never adjacent in time
  a_r10_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sw_en) && (|$past(sw_en))) |-> (sw_en == $past(sw_en)));

endmodule

// File: tb/cp_phase_seq_bench.sv
`timescale 1ns/1ps
module cp_phase_seq_bench;
  localparam int SLOT = 6;
  localparam int DEAD = 2;
  localparam int NROW = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shdn = 1'b1;
  logic       pos_low = 1'b1;
  logic       neg_low = 1'b1;
  logic [2:0] sw_en;
  logic       running;
  logic       rails_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cp_phase_seq #(.SLOT_CLKS(SLOT), .DEAD_CLKS(DEAD)) u_cp_phase_seq (
    .clk (clk), .rst_n (rst_n), .shdn (shdn), .pos_low (pos_low), .neg_low (neg_low),
    .sw_en (sw_en), .running (running), .rails_valid (rails_valid)
  );

  // Row: {shdn, pos_low, neg_low, edges to wait[5:0], exp sw[2:0], exp running, exp valid}
  // sw bit0 = doubler (storage phases), bit1 = negative transfer, bit2 = positive transfer
  localparam logic [13:0] VEC [NROW] = '{
    {3'b011, 6'd1,  3'b000, 1'b1, 1'b0},  // R2 start on demand
    {3'b011, 6'd2,  3'b001, 1'b1, 1'b0},  // R4 dead then doubler
    {3'b011, 6'd4,  3'b000, 1'b1, 1'b0},  // R4 next slot opens dead
    {3'b011, 6'd2,  3'b010, 1'b1, 1'b0},  // R3 negative transfer
    {3'b011, 6'd6,  3'b001, 1'b1, 1'b0},  // R3 positive storage
    {3'b001, 6'd6,  3'b100, 1'b1, 1'b0},  // R3 positive transfer
    {3'b000, 6'd1,  3'b100, 1'b1, 1'b1},  // R6 no mid-slot stop, R9 rise
    {3'b000, 6'd2,  3'b100, 1'b1, 1'b1},  // R6 last cycle of slot
    {3'b000, 6'd1,  3'b000, 1'b0, 1'b1},  // R6 stop after positive transfer
    {3'b000, 6'd5,  3'b000, 1'b0, 1'b1},  // R5 idle stays open
    {3'b010, 6'd1,  3'b000, 1'b1, 1'b1},  // R2 restart, R9 holds
    {3'b010, 6'd2,  3'b001, 1'b1, 1'b1},  // R4 first config doubler
    {3'b010, 6'd24, 3'b001, 1'b1, 1'b1},  // R7 wraps to storage without idle
    {3'b110, 6'd1,  3'b000, 1'b0, 1'b0},  // R8 shutdown abort
    {3'b111, 6'd4,  3'b000, 1'b0, 1'b0},  // R8 no start under shutdown
    {3'b011, 6'd1,  3'b000, 1'b1, 1'b0},  // R2 start after release
    {3'b000, 6'd2,  3'b001, 1'b1, 1'b1}   // R9 both in regulation
  };
  string tag [NROW] = '{"R2", "R4", "R4", "R3", "R3", "R3", "R6", "R6", "R6",
                        "R5", "R2", "R4", "R7", "R8", "R8", "R2", "R9"};

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_vals(input string req, input logic [2:0] esw,
                             input logic erun, input logic eval);
    checks++;
    if (sw_en !== esw || running !== erun || rails_valid !== eval) begin
      errors++;
      $display("FAIL %s: sw=%b run=%b valid=%b expected sw=%b run=%b valid=%b",
               req, sw_en, running, rails_valid, esw, erun, eval);
    end
  endtask

  // Expected switch vector k edges after a start with continuous demand
  function automatic logic [2:0] pattern(input int k);
    int slot = k / SLOT;
    int c = k % SLOT;
    if (c < DEAD) return 3'b000;
    case (slot % 4)
      0, 2:    return 3'b001;
      1:       return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  initial begin
    edges(3);
    expect_vals("R1 reset state", 3'b000, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      {shdn, pos_low, neg_low} = VEC[i][13:11];
      edges(int'(VEC[i][10:5]));
      expect_vals($sformatf("%s table row %0d", tag[i], i), VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end

    // R3 R4 R7: cycle-by-cycle scan over two full pump cycles
    shdn = 1'b1;
    edges(1);
    shdn = 1'b0; pos_low = 1'b1; neg_low = 1'b1;
    for (int k = 0; k < 8 * SLOT; k++) begin
      edges(1);
      expect_vals($sformatf("R3 scan cycle %0d", k), pattern(k), 1'b1, 1'b0);
    end

    // R8: abort while a transfer switch is closed, then R2 restart at storage
    shdn = 1'b1;
    edges(1);
    expect_vals("R8 abort during transfer", 3'b000, 1'b0, 1'b0);
    shdn = 1'b0;
    edges(1);
    expect_vals("R2 restart after abort", 3'b000, 1'b1, 1'b0);
    edges(2);
    expect_vals("R2 restart first config", 3'b001, 1'b1, 1'b0);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    edges(1);
    expect_vals("R1 reset mid-run", 3'b000, 1'b0, 1'b0);
    pos_low = 1'b0; neg_low = 1'b0;
    rst_n = 1'b1;
    edges(1);
    expect_vals("R9 valid after reset", 3'b000, 1'b0, 1'b1);

    // R6: a one-cycle demand pulse still runs a complete four-phase cycle
    pos_low = 1'b1;
    edges(1);
    pos_low = 1'b0;
    expect_vals("R6 pulse start", 3'b000, 1'b1, 1'b1);
    edges(4 * SLOT - 1);
    expect_vals("R6 pulse last slot", 3'b100, 1'b1, 1'b1);
    edges(1);
    expect_vals("R6 pulse stop", 3'b000, 1'b0, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule